// File: doc/BRIEF.md
# Receiver Wake-Up Sequencer

This block is a finite-state machine that brings a radio receiver from standby into active reception. It starts when the receive-on control input goes high while the machine is idle. From then on it walks through a fixed chain of phases without further software action. The chain is: bring up the supply regulators, start the crystal oscillator and wait a fixed time, turn on the synthesizer, optionally calibrate the VCO, wait for the synthesizer to settle, power the receive front end, calibrate the ADC, and finally put the modem into receive mode.

The analog circuits are not modelled. Each subsystem appears only as an enable output. The two calibrations also return a done input. The two fixed waits are timed by an internal counter, with cycle counts set by parameters. A one-bit configuration register selects whether the VCO calibration phase runs; it comes out of reset set to 1. Dropping receive-on at any time returns the machine to idle. A 4-bit phase output shows the current step.

There is no data stream, so every pin is a plain level-sensitive control or status signal. No pin uses a valid/ready handshake, and no input is ever back-pressured.

Top module: `rx_wake_seq`

## Requirements
- R1: After reset the phase output is 0, every enable output is low, and the VCO-calibration select bit is 1. Phase codes are: 0 idle, 1 regulators, 2 oscillator wait, 3 synthesizer on, 4 VCO calibration, 5 synthesizer settle, 6 front end on, 7 ADC calibration, 8 receive.
- R2: While the phase is 0 with `rx_on` high at a clock edge, the phase becomes 1 at that edge and `en_reg` rises.
- R3: Phase 1 lasts one cycle and is followed by phase 2. Phase 2 lasts exactly `XTAL_CYC` cycles.
- R4: After phase 2 comes phase 3, which lasts one cycle.
- R5: With the select bit at 1, phase 3 is followed by phase 4. Phase 4 asserts `en_vco_cal` and holds until `vco_cal_done` is sampled high. Phase 5 follows at that edge.
- R6: With the select bit at 0, phase 3 is followed directly by phase 5, and `en_vco_cal` never rises.
- R7: Phase 5 lasts exactly `PLL_CYC` cycles. Phase 6 follows and lasts one cycle.
- R8: After phase 6 comes phase 7, which asserts `en_adc_cal` and holds until `adc_cal_done` is sampled high. Phase 8 follows at that edge, asserts `en_modem_rx`, and stays while `rx_on` is high.
- R9: The enables accumulate. `en_reg` is high from phase 1, `en_xtal` from phase 2, `en_pll` from phase 3, and `en_rx_fe` from phase 6, each through phase 8. `en_vco_cal`, `en_adc_cal` and `en_modem_rx` are high only in phases 4, 7 and 8 respectively.
- R10: `rx_on` sampled low at a clock edge in any phase gives phase 0 with all enables low after that edge.
- R11: `vco_cal_done` and `adc_cal_done` have no effect outside phases 4 and 7 respectively.
- R12: `cfg_we` high at a clock edge loads `cfg_vcocal` into the select bit, which then governs R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_on | input | 1 | Receive-on request |
| cfg_we | input | 1 | Write strobe for the VCO-calibration select bit |
| cfg_vcocal | input | 1 | Value written to the select bit |
| vco_cal_done | input | 1 | VCO calibration finished |
| adc_cal_done | input | 1 | ADC calibration finished |
| en_reg | output | 1 | Regulator enable |
| en_xtal | output | 1 | Crystal oscillator enable |
| en_pll | output | 1 | Synthesizer enable |
| en_vco_cal | output | 1 | VCO calibration run |
| en_rx_fe | output | 1 | LNA, mixer and ADC enable |
| en_adc_cal | output | 1 | ADC calibration run |
| en_modem_rx | output | 1 | Modem receive mode |
| phase | output | 4 | Current phase code |

## Verification
Every result is due on the clock edge that samples the stimulus. The phase is a register, and the enables are decoded combinationally from it, so both are visible one edge after an input changes. The bench drives inputs on the falling edge and, at the same moment, queues the phase expected after the next rising edge. A monitor pops that expectation 1 ns after the rising edge and compares it with the phase and all seven enables. This keeps each comparison aligned to the exact cycle, including the timed waits, the calibration holds and aborts from any phase.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic [3:0] {
    PH_IDLE   = 4'd0,
    PH_REG    = 4'd1,
    PH_XTAL   = 4'd2,
    PH_PLL    = 4'd3,
    PH_VCO    = 4'd4,
    PH_SETTLE = 4'd5,
    PH_FE     = 4'd6,
    PH_ADC    = 4'd7,
    PH_RX     = 4'd8
  } phase_e;
endpackage

// File: rtl/rxw_timer.sv
module rxw_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] target,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q == target);
endmodule

// File: rtl/rxw_fsm.sv
module rxw_fsm
  import rxw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rx_on,
  input  logic   vcocal,
  input  logic   vco_done,
  input  logic   adc_done,
  input  logic   tmr_hit,
  output phase_e state_q,
  output logic   tmr_restart
);
  phase_e state_d;

  always_comb begin
    state_d = state_q;
    if (!rx_on) begin
      state_d = PH_IDLE;
    end else begin
      unique case (state_q)
        PH_IDLE:   state_d = PH_REG;
        PH_REG:    state_d = PH_XTAL;
        PH_XTAL:   if (tmr_hit) state_d = PH_PLL;
        PH_PLL:    state_d = vcocal ? PH_VCO : PH_SETTLE;
        PH_VCO:    if (vco_done) state_d = PH_SETTLE;
        PH_SETTLE: if (tmr_hit) state_d = PH_FE;
        PH_FE:     state_d = PH_ADC;
        PH_ADC:    if (adc_done) state_d = PH_RX;
        PH_RX:     state_d = PH_RX;
        default:   state_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_IDLE;
    else        state_q <= state_d;
  end

  assign tmr_restart = (state_d != state_q);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_IDLE && rx_on) |=> (state_q == PH_REG));
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on |=> (state_q == PH_IDLE));
  p_vco_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_VCO && rx_on && !vco_done) |=> (state_q == PH_VCO));
  p_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_PLL && rx_on && !vcocal) |=> (state_q == PH_SETTLE));
  p_adc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_ADC && rx_on && !adc_done) |=> (state_q == PH_ADC));
  p_rx_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_RX && rx_on) |=> (state_q == PH_RX));
endmodule

// File: rtl/rxw_drive.sv
module rxw_drive
  import rxw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e ph,
  output logic   en_reg,
  output logic   en_xtal,
  output logic   en_pll,
  output logic   en_vco_cal,
  output logic   en_rx_fe,
  output logic   en_adc_cal,
  output logic   en_modem_rx
);
  always_comb begin
    en_reg      = (ph >= PH_REG)  && (ph <= PH_RX);
    en_xtal     = (ph >= PH_XTAL) && (ph <= PH_RX);
    en_pll      = (ph >= PH_PLL)  && (ph <= PH_RX);
    en_vco_cal  = (ph == PH_VCO);
    en_rx_fe    = (ph >= PH_FE)   && (ph <= PH_RX);
    en_adc_cal  = (ph == PH_ADC);
    en_modem_rx = (ph == PH_RX);
  end

  p_cal_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_vco_cal, en_adc_cal, en_modem_rx}));
  p_fe_needs_pll_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en_rx_fe |-> (en_pll && en_xtal && en_reg));
endmodule

// File: rtl/rx_wake_seq.sv
module rx_wake_seq
  import rxw_pkg::*;
#(
  parameter int XTAL_CYC = 6,
  parameter int PLL_CYC  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_on,
  input  logic       cfg_we,
  input  logic       cfg_vcocal,
  input  logic       vco_cal_done,
  input  logic       adc_cal_done,
  output logic       en_reg,
  output logic       en_xtal,
  output logic       en_pll,
  output logic       en_vco_cal,
  output logic       en_rx_fe,
  output logic       en_adc_cal,
  output logic       en_modem_rx,
  output logic [3:0] phase
);
  localparam int MAXC = (XTAL_CYC > PLL_CYC) ? XTAL_CYC : PLL_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic          vcocal_q;
  phase_e        st;
  logic          restart, hit;
  logic [CW-1:0] target;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vcocal_q <= 1'b1;
    else if (cfg_we) vcocal_q <= cfg_vcocal;
  end

  assign target = (st == PH_XTAL) ? CW'(XTAL_CYC - 1) : CW'(PLL_CYC - 1);

  rxw_timer #(.W(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(restart), .target(target), .hit(hit)
  );

  rxw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .vcocal(vcocal_q),
    .vco_done(vco_cal_done), .adc_done(adc_cal_done), .tmr_hit(hit),
    .state_q(st), .tmr_restart(restart)
  );

  rxw_drive u_drv (
    .clk(clk), .rst_n(rst_n), .ph(st),
    .en_reg(en_reg), .en_xtal(en_xtal), .en_pll(en_pll),
    .en_vco_cal(en_vco_cal), .en_rx_fe(en_rx_fe),
    .en_adc_cal(en_adc_cal), .en_modem_rx(en_modem_rx)
  );

  assign phase = st;

  p_cfg_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (vcocal_q == $past(cfg_vcocal)));
endmodule

// File: tb/rx_wake_seq_tb.sv
`timescale 1ns/1ps
module rx_wake_seq_tb;
  localparam int XC = 6;
  localparam int PC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_on = 1'b0, cfg_we = 1'b0, cfg_vcocal = 1'b0;
  logic vdone = 1'b0, adone = 1'b0;
  logic en_reg, en_xtal, en_pll, en_vco_cal, en_rx_fe, en_adc_cal, en_modem_rx;
  logic [3:0] phase;

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  rx_wake_seq #(.XTAL_CYC(XC), .PLL_CYC(PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .cfg_we(cfg_we),
    .cfg_vcocal(cfg_vcocal), .vco_cal_done(vdone), .adc_cal_done(adone),
    .en_reg(en_reg), .en_xtal(en_xtal), .en_pll(en_pll),
    .en_vco_cal(en_vco_cal), .en_rx_fe(en_rx_fe), .en_adc_cal(en_adc_cal),
    .en_modem_rx(en_modem_rx), .phase(phase)
  );

  // R9 mapping: {reg,xtal,pll,vco,fe,adc,modem}
  function automatic logic [6:0] en_of(input logic [3:0] p);
    en_of = { (p >= 1 && p <= 8), (p >= 2 && p <= 8), (p >= 3 && p <= 8),
              (p == 4), (p >= 6 && p <= 8), (p == 7), (p == 8) };
  endfunction

  function automatic logic [6:0] en_now();
    en_now = {en_reg, en_xtal, en_pll, en_vco_cal, en_rx_fe, en_adc_cal, en_modem_rx};
  endfunction

  task automatic check(input logic [3:0] ep, input string tag);
    checks++;
    if (phase !== ep || en_now() !== en_of(ep)) begin
      failures++;
      $display("FAIL %s: phase=%0d en=%b expected phase=%0d en=%b",
               tag, phase, en_now(), ep, en_of(ep));
    end
  endtask

  // Driver: set inputs on falling edge, queue phase due after next rising edge
  task automatic step(input logic ron, input logic vd, input logic ad,
                      input logic [3:0] ep, input string tag);
    @(negedge clk);
    rx_on = ron; vdone = vd; adone = ad;
    exp_q.push_back(ep);
    tag_q.push_back(tag);
  endtask

  task automatic write_cfg(input logic v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_vcocal = v; rx_on = 1'b0; vdone = 1'b0; adone = 1'b0;
    exp_q.push_back(4'd0);
    tag_q.push_back("R12 cfg write idle");
    @(negedge clk);
    cfg_we = 1'b0;
    exp_q.push_back(4'd0);
    tag_q.push_back("R12 cfg after");
  endtask

  task automatic power_up(input bit vco_on, input int vwait, input int await_n,
                          input bit noise);
    step(1, 0, 0, 1, "R2 start");
    step(1, noise, noise, 2, "R3 reg to xtal");
    for (int i = 0; i < XC - 1; i++) step(1, noise, noise, 2, "R3 xtal hold R11");
    step(1, 0, 0, 3, "R4 pll on");
    if (vco_on) begin
      step(1, 0, noise, 4, "R5 vco cal entered");
      for (int i = 0; i < vwait; i++) step(1, 0, noise, 4, "R5 vco hold R11");
      step(1, 1, 0, 5, "R5 vco done");
    end else begin
      step(1, noise, 0, 5, "R6 vco skipped");
    end
    for (int i = 0; i < PC - 1; i++) step(1, noise, noise, 5, "R7 settle hold R11");
    step(1, 0, 0, 6, "R7 front end");
    step(1, 0, 0, 7, "R8 adc cal entered");
    for (int i = 0; i < await_n; i++) step(1, noise, 0, 7, "R8 adc hold R11");
    step(1, 0, 1, 8, "R8 receive");
    for (int i = 0; i < 3; i++) step(1, noise, noise, 8, "R8 receive stays R11");
  endtask

  // Monitor: compare 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [3:0] ep;
        string t;
        ep = exp_q.pop_front();
        t = tag_q.pop_front();
        check(ep, t);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #5;
    check(4'd0, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, "R1 idle");
    // R1 default select=1: calibration runs without any write
    power_up(1, 3, 2, 0);
    step(0, 0, 0, 0, "R10 abort from receive");
    power_up(1, 0, 0, 1);
    step(0, 0, 0, 0, "R10 abort");
    // R12 then R6
    write_cfg(0);
    power_up(0, 0, 4, 1);
    step(0, 0, 0, 0, "R10 abort");
    write_cfg(1);
    power_up(1, 5, 1, 0);
    step(0, 0, 0, 0, "R10 abort");
    // R10 aborts mid-sequence
    step(1, 0, 0, 1, "R2 start");
    step(1, 0, 0, 2, "R3 xtal");
    step(1, 0, 0, 2, "R3 xtal");
    step(0, 0, 0, 0, "R10 abort in xtal wait");
    step(0, 1, 1, 0, "R11 idle ignores done");
    step(1, 0, 0, 1, "R2 restart");
    step(1, 0, 0, 2, "R3 xtal");
    for (int i = 0; i < XC - 1; i++) step(1, 0, 0, 2, "R3 xtal hold");
    step(1, 0, 0, 3, "R4 pll");
    step(1, 0, 0, 4, "R5 vco");
    step(0, 1, 0, 0, "R10 abort in vco cal");
    step(0, 0, 0, 0, "R10 stays idle");
    @(negedge clk);
    @(negedge clk);
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule